// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit with Selectable Interrupt

This block is the bit-level engine of a two-wire serial port. The clock line SC is driven by the other end of the link. The data line SD is open-drain: the block only ever pulls it low. The block watches both lines for framing events:

- **Start:** SD falls while SC is high.
- **Stop:** SD rises while SC is high.

Between the two, the block moves eight-bit words most-significant bit first. A ninth clock after each word carries the acknowledge bit. In receive mode the block collects each word into a receive buffer and acknowledges it. In transmit mode it shifts out the content of a transmit buffer and records whether the far end acknowledged.

A single interrupt line has two possible sources, picked by a function-select input:

- **Buffer mode:** the buffer status at the end of each word's ninth clock, gated by a mask input.
- **Pin mode:** falling edges seen directly on SC or SD, each with its own enable. These work while the serial unit is idle.

The interrupt is a one-cycle pulse that also sets a pending flag. The pending flag stays set until it is cleared, and it drives the wake request that brings a sleeping controller back.

The framing state machine has three states:

- `ST_IDLE`: the bus is free.
- `ST_SHIFT`: eight data bits are in flight.
- `ST_ACK`: the ninth clock.

Its transitions are:

- **start_seen:** from any state to `ST_SHIFT`.
- **stop_seen:** from `ST_SHIFT` or `ST_ACK` to `ST_IDLE`.
- **word_shifted:** `ST_SHIFT` to `ST_ACK`, on the SC fall after the eighth rise.
- **ack_done:** `ST_ACK` to `ST_SHIFT`, on the SC fall that ends the ninth clock.

Top module: `tws_serial_if`

## Requirements
- R1: After reset the outputs read as follows: tx_empty=1, rx_full=0, nack=0, bus_busy=0, sd_drive_low=0, irq_pulse=0, irq_pending=0 and wake=0.
- R2: SD falling while SC is high makes bus_busy 1. SD rising while SC is high makes bus_busy 0. While bus_busy is 0, SD is never pulled low.
- R3: In receive mode (cfg_tx_mode=0), SD is sampled on each SC rise, most-significant bit first. After the eighth rise, the word appears on rx_data and rx_full becomes 1. rx_data changes only when a word is stored.
- R4: In receive mode, SD is pulled low from the SC fall that follows the eighth rise until the SC fall that ends the ninth clock, and at no other time.
- R5: In transmit mode (cfg_tx_mode=1), the transmit buffer is copied into the shifter at each start and at each ninth-clock end, and tx_empty becomes 1. If the buffer is empty at that moment, all ones are sent. Bits go out most-significant first: a 0 pulls SD low and a 1 releases it. Each bit is presented at start or on an SC fall, so it is valid for the whole SC high time.
- R6: In transmit mode, SD is released for the ninth clock. SD sampled high at the ninth SC rise sets nack to 1, and SD sampled low sets nack to 0. Every start clears nack.
- R7: A tx_load cycle stores tx_data and clears tx_empty. tx_load takes priority over a same-cycle copy into the shifter. An rx_read cycle clears rx_full unless a new word is stored in the same cycle.
- R8: In buffer mode (cfg_ifn=0) with cfg_sim=1, the end of the ninth clock raises the interrupt in two cases: receive mode with rx_full=1, or transmit mode, where the buffer has just been consumed. With cfg_sim=0 it raises nothing.
- R9: In pin mode (cfg_ifn=1), a falling SC raises the interrupt when cfg_sc_ie=1, and a falling SD raises it when cfg_sd_ie=1. This holds whether or not the bus is busy. Disabled edges and buffer events have no effect in this mode.
- R10: irq_pulse is high for one cycle per interrupt. The same edge sets irq_pending, which holds until an irq_clear cycle; a new pulse wins over a clear. wake always equals irq_pending.
- R11: SC and SD pass through SYNC_STAGES flip-flops before edge detection. With the default of 2, a falling SC in pin mode shows on irq_pending on the third clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_in | input | 1 | Serial clock line level |
| sd_in | input | 1 | Serial data line level |
| sd_drive_low | output | 1 | Pull SD low when 1 (open-drain enable) |
| cfg_tx_mode | input | 1 | 1 = transmit words, 0 = receive words |
| cfg_ifn | input | 1 | Interrupt source: 0 = buffer status, 1 = pin edges |
| cfg_sim | input | 1 | Mask for the buffer-status interrupt |
| cfg_sc_ie | input | 1 | Enable for the SC falling-edge interrupt |
| cfg_sd_ie | input | 1 | Enable for the SD falling-edge interrupt |
| tx_data | input | WORD_W | Word to write into the transmit buffer |
| tx_load | input | 1 | Write strobe for the transmit buffer |
| tx_empty | output | 1 | Transmit buffer has been consumed |
| rx_data | output | WORD_W | Receive buffer content |
| rx_read | input | 1 | Read acknowledge, clears rx_full |
| rx_full | output | 1 | Receive buffer holds an unread word |
| nack | output | 1 | Last transmitted word was not acknowledged |
| bus_busy | output | 1 | A transfer is framed (not idle) |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_pending | output | 1 | Latched interrupt flag |
| irq_clear | input | 1 | Clears irq_pending |
| wake | output | 1 | Wake request from sleep |

## Verification
The bound checker watches the interrupt bookkeeping on every cycle:

- the pending flag rises only with a pulse, holds until cleared, and mirrors onto wake;
- SD is never pulled while the bus is idle;
- a buffer write always clears tx_empty;
- rx_data moves only alongside a stored word;
- the mask and the per-pin enables block the pulse.

The bench scenarios cover what needs a whole telegram to show:

- that words arrive and leave most-significant bit first;
- that the acknowledge window opens and closes on the right SC falls;
- that a missing acknowledge is recorded and cleared by a new start;
- that the interrupt comes from the selected source, with the exact latency through the synchronizer.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ACK   = 2'd2
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
// Multi-stage input synchronizer with edge detection, one lane per pin.
module tws_sync #(
    parameter int STAGES = 2,
    parameter int PINS   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_lvl,
    output logic [PINS-1:0] pin_rise,
    output logic [PINS-1:0] pin_fall
);

    localparam int TOP = STAGES - 1;

    for (genvar g = 0; g < PINS; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], pin_in[g]};
                prev  <= chain[TOP];
            end
        end

        assign pin_lvl[g]  = chain[TOP];
        assign pin_rise[g] = chain[TOP] & ~prev;
        assign pin_fall[g] = ~chain[TOP] & prev;
    end

endmodule

// File: rtl/tws_frame.sv
// Framing state machine, shifter and acknowledge handling.
module tws_frame
    import tws_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_lvl,
    input  logic              sd_lvl,
    input  logic              sc_rise,
    input  logic              sc_fall,
    input  logic              sd_rise,
    input  logic              sd_fall,
    input  logic              tx_mode,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_avail,
    output tws_state_e        state,
    output logic              drive_low,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_strobe,
    output logic              tx_take,
    output logic              word_done,
    output logic              nack
);

    localparam int               CW       = $clog2(WORD_W + 1);
    localparam logic [CW-1:0]    CNT_LAST = CW'(WORD_W - 1);
    localparam logic [CW-1:0]    CNT_FULL = CW'(WORD_W);

    tws_state_e        state_nxt;
    logic [CW-1:0]     bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              out_bit;
    logic              start_ev;
    logic              stop_ev;
    logic [WORD_W-1:0] load_val;

    // SC held high across the SD change (no SC edge in the same cycle)
    assign start_ev = sd_fall & sc_lvl & ~sc_rise;
    assign stop_ev  = sd_rise & sc_lvl & ~sc_rise;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ev) state_nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (stop_ev)                                state_nxt = ST_IDLE;
                else if (start_ev)                          state_nxt = ST_SHIFT;
                else if (sc_fall && bit_cnt == CNT_FULL)    state_nxt = ST_ACK;
            end
            ST_ACK: begin
                if (stop_ev)       state_nxt = ST_IDLE;
                else if (start_ev) state_nxt = ST_SHIFT;
                else if (sc_fall)  state_nxt = ST_SHIFT;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    assign word_done = (state == ST_ACK) & sc_fall & ~start_ev & ~stop_ev;
    assign tx_take   = tx_mode & (start_ev | word_done);
    assign load_val  = tx_avail ? tx_word : '1;
    assign rx_strobe = (state == ST_SHIFT) & sc_rise & (bit_cnt == CNT_LAST) & ~tx_mode;
    assign rx_word   = {shreg[WORD_W-2:0], sd_lvl};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '1;
            out_bit <= 1'b1;
            nack    <= 1'b0;
        end else if (start_ev || word_done) begin
            bit_cnt <= '0;
            shreg   <= load_val;
            out_bit <= load_val[WORD_W-1];
            if (start_ev) nack <= 1'b0;
        end else if (state == ST_SHIFT && sc_rise && bit_cnt != CNT_FULL) begin
            shreg   <= {shreg[WORD_W-2:0], sd_lvl};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (state == ST_SHIFT && sc_fall) begin
            out_bit <= shreg[WORD_W-1];
        end else if (state == ST_ACK && sc_rise && tx_mode) begin
            nack <= sd_lvl;
        end
    end

    always_comb begin
        drive_low = 1'b0;
        unique case (state)
            ST_IDLE:  drive_low = 1'b0;
            ST_SHIFT: drive_low = tx_mode & ~out_bit;
            ST_ACK:   drive_low = ~tx_mode;
            default:  drive_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/tws_irq.sv
// Interrupt source selection, pulse and pending latch.
module tws_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_ifn,
    input  logic cfg_sim,
    input  logic cfg_sc_ie,
    input  logic cfg_sd_ie,
    input  logic sc_fall,
    input  logic sd_fall,
    input  logic word_done,
    input  logic buf_ready,
    input  logic irq_clear,
    output logic irq_pulse,
    output logic irq_pending,
    output logic wake
);

    logic pin_src;
    logic buf_src;
    logic src;

    assign pin_src = (sc_fall & cfg_sc_ie) | (sd_fall & cfg_sd_ie);
    assign buf_src = word_done & cfg_sim & buf_ready;
    assign src     = cfg_ifn ? pin_src : buf_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse   <= 1'b0;
            irq_pending <= 1'b0;
        end else begin
            irq_pulse   <= src;
            irq_pending <= src | (irq_pending & ~irq_clear);
        end
    end

    assign wake = irq_pending;

endmodule

// File: rtl/tws_serial_if.sv
module tws_serial_if
    import tws_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_in,
    input  logic              sd_in,
    output logic              sd_drive_low,
    input  logic              cfg_tx_mode,
    input  logic              cfg_ifn,
    input  logic              cfg_sim,
    input  logic              cfg_sc_ie,
    input  logic              cfg_sd_ie,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_empty,
    output logic [WORD_W-1:0] rx_data,
    input  logic              rx_read,
    output logic              rx_full,
    output logic              nack,
    output logic              bus_busy,
    output logic              irq_pulse,
    output logic              irq_pending,
    input  logic              irq_clear,
    output logic              wake
);

    localparam int PIN_SC = 0;
    localparam int PIN_SD = 1;

    logic [1:0]        lvl, rise, fall;
    tws_state_e        state;
    logic [WORD_W-1:0] tx_buf;
    logic [WORD_W-1:0] rx_word;
    logic              rx_strobe;
    logic              tx_take;
    logic              word_done;
    logic              buf_ready;

    tws_sync #(.STAGES(SYNC_STAGES), .PINS(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({sd_in, sc_in}),
        .pin_lvl  (lvl),
        .pin_rise (rise),
        .pin_fall (fall)
    );

    tws_frame #(.WORD_W(WORD_W)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_lvl    (lvl[PIN_SC]),
        .sd_lvl    (lvl[PIN_SD]),
        .sc_rise   (rise[PIN_SC]),
        .sc_fall   (fall[PIN_SC]),
        .sd_rise   (rise[PIN_SD]),
        .sd_fall   (fall[PIN_SD]),
        .tx_mode   (cfg_tx_mode),
        .tx_word   (tx_buf),
        .tx_avail  (~tx_empty),
        .state     (state),
        .drive_low (sd_drive_low),
        .rx_word   (rx_word),
        .rx_strobe (rx_strobe),
        .tx_take   (tx_take),
        .word_done (word_done),
        .nack      (nack)
    );

    // Transmit buffer: a write wins over a same-cycle consume
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            tx_empty <= 1'b1;
        end else if (tx_load) begin
            tx_buf   <= tx_data;
            tx_empty <= 1'b0;
        end else if (tx_take) begin
            tx_empty <= 1'b1;
        end
    end

    // Receive buffer: a stored word wins over a same-cycle read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (rx_strobe) begin
            rx_data <= rx_word;
            rx_full <= 1'b1;
        end else if (rx_read) begin
            rx_full <= 1'b0;
        end
    end

    assign buf_ready = cfg_tx_mode ? (tx_empty | tx_take) : rx_full;
    assign bus_busy  = (state != ST_IDLE);

    tws_irq i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ifn     (cfg_ifn),
        .cfg_sim     (cfg_sim),
        .cfg_sc_ie   (cfg_sc_ie),
        .cfg_sd_ie   (cfg_sd_ie),
        .sc_fall     (fall[PIN_SC]),
        .sd_fall     (fall[PIN_SD]),
        .word_done   (word_done),
        .buf_ready   (buf_ready),
        .irq_clear   (irq_clear),
        .irq_pulse   (irq_pulse),
        .irq_pending (irq_pending),
        .wake        (wake)
    );

endmodule

// File: rtl/tws_serial_if_chk.sv
module tws_serial_if_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_drive_low,
    input logic              cfg_ifn,
    input logic              cfg_sim,
    input logic              cfg_sc_ie,
    input logic              cfg_sd_ie,
    input logic              tx_load,
    input logic              tx_empty,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_full,
    input logic              bus_busy,
    input logic              irq_pulse,
    input logic              irq_pending,
    input logic              irq_clear,
    input logic              wake
);

    p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !sd_drive_low);

    p_rxdata_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_full);

    p_txload_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_empty);

    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_ifn) && !$past(cfg_sim)) |-> !irq_pulse);

    p_pins_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_ifn) && !$past(cfg_sc_ie) && !$past(cfg_sd_ie)) |-> !irq_pulse);

    p_pulse_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_pending);

    p_rise_needs_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> irq_pulse);

    p_pending_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_clear) |=> irq_pending);

    p_clear_works_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> (irq_pulse || !irq_pending));

    p_wake_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake == irq_pending);

endmodule

bind tws_serial_if tws_serial_if_chk #(.WORD_W(WORD_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sd_drive_low (sd_drive_low),
    .cfg_ifn      (cfg_ifn),
    .cfg_sim      (cfg_sim),
    .cfg_sc_ie    (cfg_sc_ie),
    .cfg_sd_ie    (cfg_sd_ie),
    .tx_load      (tx_load),
    .tx_empty     (tx_empty),
    .rx_data      (rx_data),
    .rx_full      (rx_full),
    .bus_busy     (bus_busy),
    .irq_pulse    (irq_pulse),
    .irq_pending  (irq_pending),
    .irq_clear    (irq_clear),
    .wake         (wake)
);

// File: tb/test_tws_serial_if.sv
`timescale 1ns/1ps
module test_tws_serial_if;

    localparam int W = 8;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sc = 1'b1;
    logic         sd_m = 1'b1;
    logic         sd_line;
    logic         sd_drive_low;
    logic         cfg_tx_mode = 1'b0, cfg_ifn = 1'b0, cfg_sim = 1'b0;
    logic         cfg_sc_ie = 1'b0, cfg_sd_ie = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_load = 1'b0, rx_read = 1'b0, irq_clear = 1'b0;
    logic         tx_empty, rx_full, nack, bus_busy, irq_pulse, irq_pending, wake;
    logic [W-1:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_pulse = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    assign sd_line = sd_m & ~sd_drive_low;

    always @(posedge clk) if (rst_n && irq_pulse) n_pulse <= n_pulse + 1;

    tws_serial_if #(.WORD_W(W), .SYNC_STAGES(2)) i_tws_serial_if (
        .clk(clk), .rst_n(rst_n), .sc_in(sc), .sd_in(sd_line),
        .sd_drive_low(sd_drive_low), .cfg_tx_mode(cfg_tx_mode), .cfg_ifn(cfg_ifn),
        .cfg_sim(cfg_sim), .cfg_sc_ie(cfg_sc_ie), .cfg_sd_ie(cfg_sd_ie),
        .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_read(rx_read), .rx_full(rx_full), .nack(nack),
        .bus_busy(bus_busy), .irq_pulse(irq_pulse), .irq_pending(irq_pending),
        .irq_clear(irq_clear), .wake(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hw();
        tick(HALF);
    endtask

    task automatic bus_start();
        sd_m = 1'b1; sc = 1'b1; hw();
        sd_m = 1'b0; hw();
        sc = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sd_m = 1'b0; hw();
        sc = 1'b1; hw();
        sd_m = 1'b1; hw();
    endtask

    task automatic put_bit(input logic b);
        sd_m = b; hw();
        sc = 1'b1; hw();
        sc = 1'b0; hw();
    endtask

    task automatic get_bit(output logic b);
        sd_m = 1'b1; hw();
        sc = 1'b1; hw();
        b = sd_line;
        sc = 1'b0; hw();
    endtask

    task automatic pulse_clear();
        irq_clear = 1'b1; tick(1);
        irq_clear = 1'b0; tick(1);
    endtask

    task automatic t_reset();
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 nack", nack, 0);
        check("R1 busy", bus_busy, 0);
        check("R1 drive", sd_drive_low, 0);
        check("R1 pending", irq_pending, 0);
        check("R1 wake", wake, 0);
    endtask

    task automatic t_rx_word(input logic [W-1:0] val, input logic ifn, input logic sim,
                             input logic exp_irq);
        int p0;
        cfg_tx_mode = 1'b0; cfg_ifn = ifn; cfg_sim = sim;
        cfg_sc_ie = 1'b0; cfg_sd_ie = 1'b0;
        tick(2);
        p0 = n_pulse;
        bus_start();
        check("R2 busy after start", bus_busy, 1);
        for (int i = W - 1; i >= 0; i--) put_bit(val[i]);
        check("R3 rx_full", rx_full, 1);
        check("R3 rx_data", rx_data, val);
        sd_m = 1'b1; hw();
        check("R4 ack drive", sd_drive_low, 1);
        sc = 1'b1; hw();
        check("R4 ack line low", sd_line, 0);
        sc = 1'b0; hw();
        check("R4 ack released", sd_drive_low, 0);
        check("R8/R9 irq", irq_pending, exp_irq);
        check("R10 pulse count", n_pulse - p0, exp_irq ? 1 : 0);
        check("R10 wake", wake, exp_irq);
        bus_stop();
        check("R2 idle after stop", bus_busy, 0);
        rx_read = 1'b1; tick(1); rx_read = 1'b0; tick(1);
        check("R7 rx_read clears", rx_full, 0);
        pulse_clear();
        check("R10 clear", irq_pending, 0);
    endtask

    task automatic t_tx_word(input logic [W-1:0] val, input logic far_nack);
        logic [W-1:0] got;
        logic b;
        cfg_tx_mode = 1'b1; cfg_ifn = 1'b0; cfg_sim = 1'b1;
        tx_data = val; tx_load = 1'b1; tick(1); tx_load = 1'b0; tick(1);
        check("R7 tx_load", tx_empty, 0);
        bus_start();
        check("R5 consumed", tx_empty, 1);
        check("R6 nack cleared by start", nack, 0);
        got = '0;
        for (int i = 0; i < W; i++) begin
            get_bit(b);
            got = {got[W-2:0], b};
        end
        check("R5 tx word", got, val);
        sd_m = far_nack; hw();
        check("R6 released in ack", sd_drive_low, 0);
        sc = 1'b1; hw();
        sc = 1'b0; hw();
        check("R6 nack", nack, far_nack);
        check("R8 tx irq", irq_pending, 1);
        bus_stop();
        check("R2 idle after stop", bus_busy, 0);
        pulse_clear();
    endtask

    task automatic t_pins();
        cfg_tx_mode = 1'b0; cfg_ifn = 1'b1; cfg_sim = 1'b0;
        cfg_sc_ie = 1'b1; cfg_sd_ie = 1'b0;
        tick(2);
        sc = 1'b0;
        tick(2);
        check("R11 not yet", irq_pending, 0);
        tick(1);
        check("R11 third edge", irq_pending, 1);
        check("R9 sc edge idle", bus_busy, 0);
        pulse_clear();
        sc = 1'b1; hw();
        cfg_sc_ie = 1'b0; cfg_sd_ie = 1'b0;
        sc = 1'b0; hw();
        sd_m = 1'b0; hw();
        check("R9 disabled edges ignored", irq_pending, 0);
        sd_m = 1'b1; hw();
        sc = 1'b1; hw();
        cfg_sd_ie = 1'b1;
        sc = 1'b0; hw();
        check("R9 sc ignored when off", irq_pending, 0);
        sd_m = 1'b0; hw();
        check("R9 sd edge", irq_pending, 1);
        sd_m = 1'b1; hw();
        sc = 1'b1; hw();
        cfg_sd_ie = 1'b0;
        pulse_clear();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_rx_word(8'hA5, 1'b0, 1'b1, 1'b1);
        t_rx_word(8'h3C, 1'b0, 1'b0, 1'b0);
        t_rx_word(8'h81, 1'b1, 1'b1, 1'b0);
        t_tx_word(8'h96, 1'b1);
        t_tx_word(8'h4E, 1'b0);
        t_pins();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule